// File: doc/BRIEF.md
# Backplane Interrupt Requester

This block lets local software raise one interrupt on a backplane with seven prioritised, active-low request lines. Software writes a control register that holds a 3-bit request level and an enable bit. While the request is armed, the block pulls down the request line for that level. When the bus runs an interrupt-acknowledge cycle for that level, the block answers with an 8-bit status/ID byte, which software programs in a second register. In the same clock edge the block disarms itself, so the request line goes high again.

The level is captured when the request is armed. It is then frozen until the enable bit goes low, either because the acknowledge cleared it or because software cleared it. A level change in the middle of a request therefore cannot move the asserted line or break acknowledge matching. An acknowledge for any other level is passed downstream at once. Software polls the live enable bit to learn when its interrupt has been serviced.

Top module: `bus_irq_requester`

## Requirements
- R1: After reset the enable bit is 0, the level is 0, the vector register holds 0x0F, all `irq_n` lines are high and `iack_dtack` is low.
- R2: A write to the control offset (0x8C) while the request is disarmed loads the level from data bits 2:0 and the enable bit from data bit 3. A read of that offset returns the enable bit in bit 3, the level in bits 2:0 and zeros above.
- R3: While the request is enabled with level L (1 to 7), `irq_n[L-1]` is low and every other line is high. While it is disabled, all lines are high.
- R4: A level of 0 pulls no line low, even with the enable bit set.
- R5: While enabled, control writes leave the level unchanged. Such a write with data bit 3 at 0 clears the enable bit and keeps the level. A write with bit 3 at 1 changes nothing.
- R6: The vector register at offset 0x98 is written and read back over all 8 bits.
- R7: A matched acknowledge raises `iack_dtack` for exactly one cycle, starting on the next clock, with `iack_vector` equal to the vector register. A matched acknowledge is a one-cycle `iack_strobe` whose `iack_level` equals the latched level, while the request is enabled with a nonzero level. On that same edge the enable bit clears and all request lines go high.
- R8: Any other acknowledge strobe drives `iack_pass` high in that same cycle. It gives no `iack_dtack` and leaves the enable bit unchanged. This covers a level mismatch, a disarmed request, or a level of 0.
- R9: When a matched acknowledge and a control write fall in the same cycle, the acknowledge wins. The enable bit ends at 0, the level is kept, and the acknowledge is answered.
- R10: A read of any other offset, or with `reg_rd` low, returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read enable |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| iack_strobe | input | 1 | One-cycle acknowledge-cycle strobe |
| iack_level | input | 3 | Level code of the acknowledge cycle |
| iack_pass | output | 1 | Acknowledge not claimed; pass grant downstream |
| iack_dtack | output | 1 | Acknowledge answered, one-cycle pulse |
| iack_vector | output | 8 | Status/ID byte returned with `iack_dtack` |
| irq_n | output | 7 | Active-low request lines, bit k for level k+1 |

## Verification
The bench sweeps every level with the enable bit both clear and set, and checks which line is low. A line decoder that is off by one, or that asserts a line for level 0, fails this sweep. For each armed level it runs every other acknowledge code before the matching one. A design that claims the wrong acknowledge, or that lets a foreign acknowledge disarm it, shows a stray `iack_dtack` or a lost enable bit. The bench also writes a new level while the request is armed, and fires a write and a matched acknowledge in the same cycle. A design without the level freeze moves its request line, and one with the wrong priority stays armed after it has been serviced.

// File: rtl/bir_pkg.sv
package bir_pkg;
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_CTRL = 2'd1,
      SEL_VEC  = 2'd2
   } bir_sel_e;
endpackage

// File: rtl/bir_regs.sv
module bir_regs
   import bir_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned LVL_W       = 3,
   parameter int unsigned CTRL_OFFSET = 'h8C,
   parameter int unsigned VEC_OFFSET  = 'h98,
   parameter int unsigned VEC_RESET   = 'h0F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              rd,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              ack_hit,
   output logic              en_o,
   output logic [LVL_W-1:0]  lvl_o,
   output logic [DATA_W-1:0] vec_o
);
   localparam int unsigned EN_BIT = LVL_W;
   localparam logic [DATA_W-1:0] VEC_INIT = DATA_W'(VEC_RESET);

   bir_sel_e         sel;
   logic             en_q;
   logic [LVL_W-1:0] lvl_q;
   logic [DATA_W-1:0] vec_q;

   always_comb begin
      if (addr == ADDR_W'(CTRL_OFFSET))     sel = SEL_CTRL;
      else if (addr == ADDR_W'(VEC_OFFSET)) sel = SEL_VEC;
      else                                  sel = SEL_NONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         lvl_q <= '0;
         vec_q <= VEC_INIT;
      end else begin
         if (ack_hit) begin
            en_q <= 1'b0;
         end else if (wr && sel == SEL_CTRL) begin
            if (!en_q) begin
               lvl_q <= wdata[LVL_W-1:0];
               en_q  <= wdata[EN_BIT];
            end else if (!wdata[EN_BIT]) begin
               en_q <= 1'b0;
            end
         end
         if (wr && sel == SEL_VEC) vec_q <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      if (rd) begin
         case (sel)
            SEL_CTRL: rdata[EN_BIT:0] = {en_q, lvl_q};
            SEL_VEC:  rdata = vec_q;
            default:  rdata = '0;
         endcase
      end
   end

   assign en_o  = en_q;
   assign lvl_o = lvl_q;
   assign vec_o = vec_q;
endmodule

// File: rtl/bir_ack_match.sv
module bir_ack_match #(
   parameter int unsigned LVL_W  = 3,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strobe,
   input  logic [LVL_W-1:0]  ack_lvl,
   input  logic              en,
   input  logic [LVL_W-1:0]  lvl,
   input  logic [DATA_W-1:0] vec,
   output logic              hit,
   output logic              pass,
   output logic              dtack,
   output logic [DATA_W-1:0] vec_out
);
   logic              dtack_q;
   logic [DATA_W-1:0] vec_q;

   always_comb begin
      hit  = strobe && en && (lvl != '0) && (ack_lvl == lvl);
      pass = strobe && !hit;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dtack_q <= 1'b0;
         vec_q   <= '0;
      end else begin
         dtack_q <= hit;
         if (hit) vec_q <= vec;
      end
   end

   assign dtack   = dtack_q;
   assign vec_out = vec_q;
endmodule

// File: rtl/bir_line_drv.sv
module bir_line_drv #(
   parameter int unsigned NUM_LINES = 7,
   parameter int unsigned LVL_W     = 3
) (
   input  logic                 en,
   input  logic [LVL_W-1:0]     lvl,
   output logic [NUM_LINES-1:0] irq_n
);
   for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
      assign irq_n[k] = !(en && (lvl == LVL_W'(k + 1)));
   end
endmodule

// File: rtl/bus_irq_requester.sv
module bus_irq_requester #(
   parameter int unsigned NUM_LEVELS  = 7,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned CTRL_OFFSET = 'h8C,
   parameter int unsigned VEC_OFFSET  = 'h98,
   parameter int unsigned VEC_RESET   = 'h0F
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_wr,
   input  logic                  reg_rd,
   input  logic [ADDR_W-1:0]     reg_addr,
   input  logic [DATA_W-1:0]     reg_wdata,
   output logic [DATA_W-1:0]     reg_rdata,
   input  logic                  iack_strobe,
   input  logic [$clog2(NUM_LEVELS+1)-1:0] iack_level,
   output logic                  iack_pass,
   output logic                  iack_dtack,
   output logic [DATA_W-1:0]     iack_vector,
   output logic [NUM_LEVELS-1:0] irq_n
);
   localparam int unsigned LVL_W = $clog2(NUM_LEVELS + 1);

   if (NUM_LEVELS < 1) begin : g_bad_levels
      $error("NUM_LEVELS must be at least 1");
   end
   if (DATA_W < LVL_W + 1) begin : g_bad_width
      $error("DATA_W too narrow for level and enable fields");
   end
   if (CTRL_OFFSET == VEC_OFFSET) begin : g_bad_map
      $error("control and vector offsets collide");
   end
   if (CTRL_OFFSET >= (1 << ADDR_W) || VEC_OFFSET >= (1 << ADDR_W)) begin : g_bad_addr
      $error("register offset outside address range");
   end

   logic              ctrl_en;
   logic [LVL_W-1:0]  ctrl_lvl;
   logic [DATA_W-1:0] vec_reg;
   logic              ack_hit;

   bir_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LVL_W(LVL_W),
      .CTRL_OFFSET(CTRL_OFFSET), .VEC_OFFSET(VEC_OFFSET), .VEC_RESET(VEC_RESET)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr(reg_wr), .rd(reg_rd), .addr(reg_addr), .wdata(reg_wdata),
      .rdata(reg_rdata), .ack_hit(ack_hit),
      .en_o(ctrl_en), .lvl_o(ctrl_lvl), .vec_o(vec_reg)
   );

   bir_ack_match #(.LVL_W(LVL_W), .DATA_W(DATA_W)) u_ack (
      .clk(clk), .rst_n(rst_n),
      .strobe(iack_strobe), .ack_lvl(iack_level),
      .en(ctrl_en), .lvl(ctrl_lvl), .vec(vec_reg),
      .hit(ack_hit), .pass(iack_pass),
      .dtack(iack_dtack), .vec_out(iack_vector)
   );

   bir_line_drv #(.NUM_LINES(NUM_LEVELS), .LVL_W(LVL_W)) u_lines (
      .en(ctrl_en), .lvl(ctrl_lvl), .irq_n(irq_n)
   );
endmodule

// File: rtl/bir_checker.sv
module bir_checker #(
   parameter int unsigned NUM_LEVELS = 7,
   parameter int unsigned LVL_W      = 3
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  iack_strobe,
   input logic [LVL_W-1:0]      iack_level,
   input logic                  iack_pass,
   input logic                  iack_dtack,
   input logic [NUM_LEVELS-1:0] irq_n,
   input logic                  en,
   input logic [LVL_W-1:0]      lvl
);
   AST_LINE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~irq_n)); // R3
   AST_LVL_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (en && lvl == '0) |-> (&irq_n)); // R4
   AST_LEVEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> $stable(lvl)); // R5
   AST_MATCH_DTACK: assert property (@(posedge clk) disable iff (!rst_n)
      (iack_strobe && en && lvl != '0 && iack_level == lvl) |=> (iack_dtack && !en && (&irq_n))); // R7
   AST_DTACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      iack_dtack |=> !iack_dtack); // R7
   AST_PASS_NO_DTACK: assert property (@(posedge clk) disable iff (!rst_n)
      iack_pass |=> !iack_dtack); // R8
endmodule

bind bus_irq_requester bir_checker #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .iack_strobe(iack_strobe), .iack_level(iack_level),
   .iack_pass(iack_pass), .iack_dtack(iack_dtack),
   .irq_n(irq_n), .en(ctrl_en), .lvl(ctrl_lvl)
);

// File: tb/tb_bus_irq_requester.sv
module tb_bus_irq_requester;
   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] A_CTRL = 8'h8C;
   localparam logic [7:0] A_VEC  = 8'h98;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0;
   logic [7:0] reg_addr = '0, reg_wdata = '0, reg_rdata;
   logic       iack_strobe = 1'b0;
   logic [2:0] iack_level = '0;
   logic       iack_pass, iack_dtack;
   logic [7:0] iack_vector;
   logic [6:0] irq_n;

   int total = 0;
   int bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bus_irq_requester dut (
      .clk(clk), .rst_n(rst_n),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .iack_strobe(iack_strobe), .iack_level(iack_level),
      .iack_pass(iack_pass), .iack_dtack(iack_dtack),
      .iack_vector(iack_vector), .irq_n(irq_n)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      reg_rd = 1'b0;
   endtask

   function automatic logic [6:0] exp_lines(input int e, input int lv);
      if (e != 0 && lv != 0) return ~(7'(1) << (lv - 1));
      return 7'h7F;
   endfunction

   initial begin
      #(CLK_PERIOD * 100000);
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1 irq_n", int'(irq_n), 'h7F);
      chk("R1 dtack", int'(iack_dtack), 0);
      rd(A_CTRL, d); chk("R1 ctrl", int'(d), 0);
      rd(A_VEC, d);  chk("R1 vec", int'(d), 'h0F);

      // R2 R3 R4 sweep of level and enable
      for (int lv = 0; lv < 8; lv++) begin
         for (int e = 0; e < 2; e++) begin
            wr(A_CTRL, 8'h00);
            wr(A_CTRL, 8'((e << 3) | lv));
            rd(A_CTRL, d);
            chk("R2 ctrl readback", int'(d), (e << 3) | lv);
            if (lv == 0) chk("R4 level zero lines", int'(irq_n), int'(exp_lines(e, lv)));
            else         chk("R3 lines", int'(irq_n), int'(exp_lines(e, lv)));
         end
      end

      // R6 vector register
      foreach (d[i]) ;
      for (int i = 0; i < 4; i++) begin
         logic [7:0] p;
         p = (i == 0) ? 8'hA5 : (i == 1) ? 8'h5A : (i == 2) ? 8'hFF : 8'h00;
         wr(A_VEC, p);
         rd(A_VEC, d);
         chk("R6 vec readback", int'(d), int'(p));
      end

      // R10 unmapped and no-read
      rd(8'h00, d); chk("R10 addr 00", int'(d), 0);
      rd(8'h8D, d); chk("R10 addr 8D", int'(d), 0);
      rd(8'hFF, d); chk("R10 addr FF", int'(d), 0);
      reg_addr = A_VEC; #1 chk("R10 rd low", int'(reg_rdata), 0);

      // R5 level frozen while enabled
      wr(A_CTRL, 8'h00);
      wr(A_CTRL, 8'h0A);
      wr(A_CTRL, 8'h0E);
      rd(A_CTRL, d); chk("R5 level kept", int'(d), 'h0A);
      chk("R5 line kept", int'(irq_n), int'(exp_lines(1, 2)));
      wr(A_CTRL, 8'h05);
      rd(A_CTRL, d); chk("R5 clear keeps level", int'(d), 'h02);
      chk("R5 lines idle", int'(irq_n), 'h7F);
      wr(A_CTRL, 8'h0E);
      rd(A_CTRL, d); chk("R5 relatch", int'(d), 'h0E);

      // R7 R8 acknowledge sweep
      for (int lv = 1; lv < 8; lv++) begin
         logic [7:0] v;
         v = 8'((lv * 37 + 11) & 'hFF);
         wr(A_CTRL, 8'h00);
         wr(A_VEC, v);
         wr(A_CTRL, 8'(8 | lv));
         for (int a = 0; a < 8; a++) begin
            if (a == lv) continue;
            @(negedge clk);
            iack_strobe = 1'b1; iack_level = 3'(a);
            #1 chk("R8 pass on mismatch", int'(iack_pass), 1);
            @(negedge clk);
            iack_strobe = 1'b0;
            #1 chk("R8 no dtack", int'(iack_dtack), 0);
            chk("R8 line held", int'(irq_n), int'(exp_lines(1, lv)));
            rd(A_CTRL, d); chk("R8 still armed", int'(d), 8 | lv);
         end
         @(negedge clk);
         iack_strobe = 1'b1; iack_level = 3'(lv);
         #1 chk("R7 no pass on match", int'(iack_pass), 0);
         @(negedge clk);
         iack_strobe = 1'b0;
         #1 chk("R7 dtack", int'(iack_dtack), 1);
         chk("R7 vector", int'(iack_vector), int'(v));
         chk("R7 lines released", int'(irq_n), 'h7F);
         rd(A_CTRL, d); chk("R7 enable cleared", int'(d), lv);
         @(negedge clk);
         #1 chk("R7 dtack one cycle", int'(iack_dtack), 0);
      end

      // R8 disarmed and level-zero acknowledges
      wr(A_CTRL, 8'h03);
      @(negedge clk);
      iack_strobe = 1'b1; iack_level = 3'd3;
      #1 chk("R8 pass when disarmed", int'(iack_pass), 1);
      @(negedge clk);
      iack_strobe = 1'b0;
      #1 chk("R8 no dtack disarmed", int'(iack_dtack), 0);
      wr(A_CTRL, 8'h08);
      @(negedge clk);
      iack_strobe = 1'b1; iack_level = 3'd0;
      #1 chk("R8 pass level zero", int'(iack_pass), 1);
      @(negedge clk);
      iack_strobe = 1'b0;
      #1 chk("R8 no dtack level zero", int'(iack_dtack), 0);
      rd(A_CTRL, d); chk("R8 level zero stays armed", int'(d), 'h08);

      // R9 write and matched acknowledge in one cycle
      wr(A_CTRL, 8'h00);
      wr(A_CTRL, 8'h0B);
      @(negedge clk);
      iack_strobe = 1'b1; iack_level = 3'd3;
      reg_wr = 1'b1; reg_addr = A_CTRL; reg_wdata = 8'h0D;
      @(negedge clk);
      iack_strobe = 1'b0; reg_wr = 1'b0;
      #1 chk("R9 dtack", int'(iack_dtack), 1);
      rd(A_CTRL, d); chk("R9 ack wins", int'(d), 'h03);
      chk("R9 lines idle", int'(irq_n), 'h7F);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule